// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the scan timing for a raster display in the pixel clock domain. It runs a column counter and a line counter, and from them drives horizontal sync, vertical sync, a data-enable strobe and the coordinates of the pixel currently being shown. Each axis is described by four programmed values: active size, front porch, sync width and a combined "sync plus back porch" span. That span runs from the first sync pixel to the end of the line or frame. The line and frame totals are not programmed. They are derived as active + front porch + span.

Software presents a new timing set on the configuration pins and pulses `cfg_load`. The set is held as pending and moves into the working set only when the raster wraps from the last pixel of the last line to pixel (0,0). A frame is therefore never built from a mix of two settings. Per-axis polarity bits select active-high or active-low sync. A transmit-clock polarity bit is carried through with the same frame-start timing. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `raster_timing_gen`

## Requirements
- R1: The column counter runs from 0 to Htot-1, where Htot = `act_w` + `fp_x` + `sb_x`. The line counter advances once at each column wrap and runs from 0 to Vtot-1, where Vtot = `act_h` + `fp_y` + `sb_y`.
- R2: Within a line, the columns fall in this order: active columns [0, act_w), front porch, sync pulse starting at column act_w+fp_x, then the tail of the span. Lines within a frame follow the same order. `de` rises only with `pix_x` = 0.
- R3: `hsync` is at its active level for columns [act_w+fp_x, act_w+fp_x+sw_x). `vsync` is at its active level for lines [act_h+fp_y, act_h+fp_y+sw_y). A polarity bit of 1 means the active level is high; 0 means it is low.
- R4: `de` is 1 only when the column is below `act_w` and the line is below `act_h`. While `de` is 1, `pix_x` and `pix_y` equal the column and line. While `de` is 0, both are 0.
- R5: All outputs are registered. The first rising edge after reset is released shows position (0,0), and each later edge shows the next position.
- R6: A high `cfg_load` at a clock edge copies the configuration pins into a pending set. The working set takes the pending set only at the edge where the raster wraps to (0,0). A load in mid-frame, or a change of the pins without `cfg_load`, does not alter the frame in progress.
- R7: While `rst` is high at a clock edge, both counters go to 0, `de`, `pix_x` and `pix_y` go to 0, and each sync output takes the inverse of its polarity pin. The working and pending sets take the pin values.
- R8: With 720/19/119/62 on the horizontal axis, the line is 858 columns long and `hsync` is active on columns 739 to 800. With 480/8/37/6 on the vertical axis, the frame is 525 lines long and `vsync` is active on lines 488 to 493.
- R9: `txc_pol_o` equals the transmit-clock polarity bit of the working set, with the same one-cycle output timing as the other outputs.
- R10: When the sync width is larger than the span, the sync pulse is cut off at the end of the line or frame. It never carries into the next line or frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Copies the configuration pins into the pending set |
| act_w | input | 12 | Active width in pixels |
| act_h | input | 12 | Active height in lines |
| fp_x | input | 12 | Horizontal front porch |
| fp_y | input | 12 | Vertical front porch |
| sb_x | input | 12 | Horizontal sync-plus-back-porch span |
| sb_y | input | 12 | Vertical sync-plus-back-porch span |
| sw_x | input | 12 | Horizontal sync width |
| sw_y | input | 12 | Vertical sync width |
| hs_pol | input | 1 | 1: hsync active high |
| vs_pol | input | 1 | 1: vsync active high |
| txc_pol | input | 1 | Transmit-clock polarity bit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Current column, 0 outside the active area |
| pix_y | output | 12 | Current line, 0 outside the active area |
| txc_pol_o | output | 1 | Working transmit-clock polarity |

## Verification
The bench loads the 858-column line and the 525-line frame and measures them. It checks where sync starts, how wide it is and the full period. A design that read the span as the back porch alone would make lines 62 columns too long and put sync in the wrong place. A new set is loaded in the middle of a frame, and the pins are then changed without a load. A design that swapped its working set at a line wrap, or that followed the pins directly, would change the length of the current frame and would be caught. A further set uses a sync width larger than the span, so a design that let the pulse wrap into the next line shows a stray active column 0. The bench also asserts reset with both polarities to catch sync outputs that idle at the wrong level.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Region an axis counter is in; the order is the scan order within a line or frame
  typedef enum logic [1:0] {
    RG_ACTIVE = 2'd0,
    RG_FRONT  = 2'd1,
    RG_SYNC   = 2'd2,
    RG_TAIL   = 2'd3
  } region_e;

  // Polarity and transmit-clock flags
  typedef struct packed {
    logic hs_hi;
    logic vs_hi;
    logic txc;
  } pol_t;

endpackage

// File: rtl/raster_axis.sv
module raster_axis
  import raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] act,
  input  logic [CW-1:0] fp,
  input  logic [CW-1:0] sb,
  input  logic [CW-1:0] sw,
  output logic [CW+1:0] cnt,
  output logic          last,
  output region_e       region
);

  localparam int TW = CW + 2;

  logic [TW-1:0] tot;
  logic [TW-1:0] sync_beg;
  logic [TW-1:0] sync_end;

  // Totals are derived: active + front porch + (sync + back porch) span
  always_comb begin
    tot      = TW'(act) + TW'(fp) + TW'(sb);
    sync_beg = TW'(act) + TW'(fp);
    sync_end = sync_beg + TW'(sw);
  end

  assign last = (cnt + TW'(1)) >= tot;

  // Region decode; a sync wider than the span ends at the wrap
  always_comb begin
    if (cnt < TW'(act))       region = RG_ACTIVE;
    else if (cnt < sync_beg)  region = RG_FRONT;
    else if (cnt < sync_end)  region = RG_SYNC;
    else                      region = RG_TAIL;
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= last ? '0 : cnt + TW'(1);
  end

  // R1: the counter only moves when told to advance
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));

  // R1: the counter stays below the derived total
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (tot != '0) |-> (cnt < tot));

endmodule

// File: rtl/raster_shadow.sv
module raster_shadow
  import raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            swap,
  input  logic [4*CW-1:0] h_in,
  input  logic [4*CW-1:0] v_in,
  input  pol_t            pol_in,
  output logic [4*CW-1:0] h_work,
  output logic [4*CW-1:0] v_work,
  output pol_t            pol_work
);

  logic [4*CW-1:0] h_pend;
  logic [4*CW-1:0] v_pend;
  pol_t            pol_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pend   <= h_in;
      v_pend   <= v_in;
      pol_pend <= pol_in;
      h_work   <= h_in;
      v_work   <= v_in;
      pol_work <= pol_in;
    end else begin
      if (swap) begin
        h_work   <= h_pend;
        v_work   <= v_pend;
        pol_work <= pol_pend;
      end
      if (load) begin
        h_pend   <= h_in;
        v_pend   <= v_in;
        pol_pend <= pol_in;
      end
    end
  end

  // R6: the working set changes only at a frame wrap
  p_work_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !swap |=> ($stable(h_work) && $stable(v_work) && $stable(pol_work)));

endmodule

// File: rtl/raster_outreg.sv
module raster_outreg
  import raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  pol_t          rst_pol,
  input  pol_t          pol,
  input  region_e       h_reg,
  input  region_e       v_reg,
  input  logic [CW-1:0] hc,
  input  logic [CW-1:0] vc,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] px,
  output logic [CW-1:0] py,
  output logic          txc
);

  logic in_act;
  assign in_act = (h_reg == RG_ACTIVE) && (v_reg == RG_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= ~rst_pol.hs_hi;
      vsync <= ~rst_pol.vs_hi;
      de    <= 1'b0;
      px    <= '0;
      py    <= '0;
      txc   <= rst_pol.txc;
    end else begin
      hsync <= (h_reg == RG_SYNC) ? pol.hs_hi : ~pol.hs_hi;
      vsync <= (v_reg == RG_SYNC) ? pol.vs_hi : ~pol.vs_hi;
      de    <= in_act;
      px    <= in_act ? hc : '0;
      py    <= in_act ? vc : '0;
      txc   <= pol.txc;
    end
  end

  // R2: data enable always starts at column zero
  p_de_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> (px == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [CW-1:0] act_w,
  input  logic [CW-1:0] act_h,
  input  logic [CW-1:0] fp_x,
  input  logic [CW-1:0] fp_y,
  input  logic [CW-1:0] sb_x,
  input  logic [CW-1:0] sb_y,
  input  logic [CW-1:0] sw_x,
  input  logic [CW-1:0] sw_y,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic          txc_pol,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          txc_pol_o
);

  localparam int TW = CW + 2;
  localparam int FW = 4 * CW;

  pol_t            pol_in;
  pol_t            pol_work;
  logic [FW-1:0]   h_work;
  logic [FW-1:0]   v_work;
  logic            h_last;
  logic            v_last;
  logic            frame_wrap;
  logic [TW-1:0]   h_cnt;
  logic [TW-1:0]   v_cnt;
  region_e         h_reg;
  region_e         v_reg;

  assign pol_in     = '{hs_hi: hs_pol, vs_hi: vs_pol, txc: txc_pol};
  assign frame_wrap = h_last && v_last;

  raster_shadow #(.CW(CW)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .swap     (frame_wrap),
    .h_in     ({act_w, fp_x, sb_x, sw_x}),
    .v_in     ({act_h, fp_y, sb_y, sw_y}),
    .pol_in   (pol_in),
    .h_work   (h_work),
    .v_work   (v_work),
    .pol_work (pol_work)
  );

  raster_axis #(.CW(CW)) u_haxis (
    .clk    (clk),
    .rst    (rst),
    .adv    (1'b1),
    .act    (h_work[4*CW-1:3*CW]),
    .fp     (h_work[3*CW-1:2*CW]),
    .sb     (h_work[2*CW-1:CW]),
    .sw     (h_work[CW-1:0]),
    .cnt    (h_cnt),
    .last   (h_last),
    .region (h_reg)
  );

  raster_axis #(.CW(CW)) u_vaxis (
    .clk    (clk),
    .rst    (rst),
    .adv    (h_last),
    .act    (v_work[4*CW-1:3*CW]),
    .fp     (v_work[3*CW-1:2*CW]),
    .sb     (v_work[2*CW-1:CW]),
    .sw     (v_work[CW-1:0]),
    .cnt    (v_cnt),
    .last   (v_last),
    .region (v_reg)
  );

  raster_outreg #(.CW(CW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .rst_pol (pol_in),
    .pol     (pol_work),
    .h_reg   (h_reg),
    .v_reg   (v_reg),
    .hc      (h_cnt[CW-1:0]),
    .vc      (v_cnt[CW-1:0]),
    .hsync   (hsync),
    .vsync   (vsync),
    .de      (de),
    .px      (pix_x),
    .py      (pix_y),
    .txc     (txc_pol_o)
  );

endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic [CW-1:0] act_w, act_h, fp_x, fp_y, sb_x, sb_y, sw_x, sw_y;
  logic          hs_pol, vs_pol, txc_pol;
  logic          hsync, vsync, de, txc_pol_o;
  logic [CW-1:0] pix_x, pix_y;

  always #10 clk = ~clk;

  raster_timing_gen #(.CW(CW)) i_raster_timing_gen (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .act_w(act_w), .act_h(act_h), .fp_x(fp_x), .fp_y(fp_y),
    .sb_x(sb_x), .sb_y(sb_y), .sw_x(sw_x), .sw_y(sw_y),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .txc_pol(txc_pol),
    .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .txc_pol_o(txc_pol_o)
  );

  typedef struct {
    bit hs; bit vs; bit de; int px; int py; bit txc;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: working/pending sets and counters from the requirements
  int wh[4], wv[4], ph[4], pv[4];
  bit wp[3], pp[3];
  int mh = 0, mv = 0;

  function automatic int region(int c, int a, int f, int b, int s);
    if (c < a) return 0;
    if (c < a + f) return 1;
    if (c < a + f + s) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    int rh, rv, ht, vt;
    bit hl, vl;
    if (rst) begin
      e.hs = !hs_pol; e.vs = !vs_pol; e.de = 0; e.px = 0; e.py = 0; e.txc = txc_pol;
      q.push_back(e);
      wh = '{int'(act_w), int'(fp_x), int'(sb_x), int'(sw_x)};
      wv = '{int'(act_h), int'(fp_y), int'(sb_y), int'(sw_y)};
      wp = '{hs_pol, vs_pol, txc_pol};
      ph = wh; pv = wv; pp = wp;
      mh = 0; mv = 0;
    end else begin
      rh = region(mh, wh[0], wh[1], wh[2], wh[3]);
      rv = region(mv, wv[0], wv[1], wv[2], wv[3]);
      e.de  = (rh == 0) && (rv == 0);
      e.px  = e.de ? mh : 0;
      e.py  = e.de ? mv : 0;
      e.hs  = (rh == 2) ? wp[0] : !wp[0];
      e.vs  = (rv == 2) ? wp[1] : !wp[1];
      e.txc = wp[2];
      q.push_back(e);
      ht = wh[0] + wh[1] + wh[2];
      vt = wv[0] + wv[1] + wv[2];
      hl = (mh + 1 >= ht);
      vl = (mv + 1 >= vt);
      if (hl && vl) begin wh = ph; wv = pv; wp = pp; end
      if (hl) begin mh = 0; mv = vl ? 0 : mv + 1; end
      else mh = mh + 1;
      if (cfg_load) begin
        ph = '{int'(act_w), int'(fp_x), int'(sb_x), int'(sw_x)};
        pv = '{int'(act_h), int'(fp_y), int'(sb_y), int'(sw_y)};
        pp = '{hs_pol, vs_pol, txc_pol};
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(de === e.de, "R4 de", int'(de), int'(e.de));
      chk(int'(pix_x) == e.px, "R4 pix_x", int'(pix_x), e.px);
      chk(int'(pix_y) == e.py, "R4 pix_y", int'(pix_y), e.py);
      chk(hsync === e.hs, "R3 hsync (R10 clip)", int'(hsync), int'(e.hs));
      chk(vsync === e.vs, "R3 vsync", int'(vsync), int'(e.vs));
      chk(txc_pol_o === e.txc, "R9 txc_pol_o", int'(txc_pol_o), int'(e.txc));
    end
  end

  task automatic set_cfg(input int aw, fx, bx, wx, ah, fy, by, wy, input bit hp, vp, tp);
    act_w = CW'(aw); fp_x = CW'(fx); sb_x = CW'(bx); sw_x = CW'(wx);
    act_h = CW'(ah); fp_y = CW'(fy); sb_y = CW'(by); sw_y = CW'(wy);
    hs_pol = hp; vs_pol = vp; txc_pol = tp;
  endtask

  task automatic wait_frame_start(input bit txc_want);
    int n = 0;
    while (!(de === 1'b1 && pix_x == 0 && pix_y == 0 && txc_pol_o === txc_want) && n < 20000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n, w;
    set_cfg(720, 19, 119, 62, 4, 1, 3, 1, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    // R7: reset levels, active-low syncs idle high
    chk(hsync === 1'b1, "R7 hsync idle", int'(hsync), 1);
    chk(vsync === 1'b1, "R7 vsync idle", int'(vsync), 1);
    chk(de === 1'b0, "R7 de", int'(de), 0);
    chk(pix_x == 0 && pix_y == 0, "R7 coords", int'(pix_x), 0);
    rst = 1'b0;
    @(negedge clk);
    // R5: first edge after release shows (0,0)
    chk(de === 1'b1 && pix_x == 0 && pix_y == 0, "R5 first position", int'(de), 1);
    // R8 horizontal: sync start, width, line total (R1, R2)
    n = 0;
    while (hsync !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    chk(n == 739, "R8 hsync start column", n, 739);
    w = 0;
    while (hsync === 1'b0 && w < 2000) begin @(negedge clk); w++; end
    chk(w == 62, "R8 hsync width", w, 62);
    n = n + w;
    while (!(de === 1'b1 && pix_x == 0) && n < 4000) begin @(negedge clk); n++; end
    chk(n == 858, "R1 R8 line total", n, 858);
    chk(pix_y == 1, "R1 line advance", int'(pix_y), 1);
    // R6: mid-frame load of a new set, then pin changes without load
    set_cfg(4, 1, 2, 1, 480, 8, 37, 6, 1'b1, 1'b1, 1'b0);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    set_cfg(3, 3, 3, 3, 3, 3, 3, 3, 1'b0, 1'b0, 1'b1);
    n = 1;
    while (!(de === 1'b1 && pix_x == 0) && n < 4000) begin @(negedge clk); n++; end
    chk(n == 858, "R6 line length kept mid-frame", n, 858);
    chk(txc_pol_o === 1'b1, "R6 txc kept mid-frame", int'(txc_pol_o), 1);
    wait_frame_start(1'b0);
    chk(txc_pol_o === 1'b0 && pix_y == 0, "R6 new set at frame start", int'(txc_pol_o), 0);
    // Queue the next set now; it must wait for the end of this frame
    set_cfg(6, 2, 2, 5, 3, 1, 1, 3, 1'b0, 1'b1, 1'b1);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    // R8 vertical: 7-column lines, sync lines 488..493, 525 lines
    n = 1;
    while (vsync !== 1'b1 && n < 10000) begin @(negedge clk); n++; end
    chk(n == 488 * 7, "R8 vsync start", n, 488 * 7);
    w = 0;
    while (vsync === 1'b1 && w < 1000) begin @(negedge clk); w++; end
    chk(w == 6 * 7, "R8 vsync width", w, 6 * 7);
    n = n + w;
    while (!(de === 1'b1 && pix_x == 0 && pix_y == 0) && n < 10000) begin @(negedge clk); n++; end
    chk(n == 525 * 7, "R8 frame total", n, 525 * 7);
    chk(txc_pol_o === 1'b1, "R6 queued set applied", int'(txc_pol_o), 1);
    // R10: sync wider than the span, clipped at column 9 (line of 10)
    n = 0;
    while (hsync !== 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk(n == 8, "R10 hsync start", n, 8);
    w = 0;
    while (hsync === 1'b0 && w < 100) begin @(negedge clk); w++; end
    chk(w == 2, "R10 hsync clipped width", w, 2);
    repeat (120) @(negedge clk);
    // R7: reset mid-run with the other polarity pair
    set_cfg(6, 2, 2, 5, 3, 1, 1, 3, 1'b1, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk(hsync === 1'b0 && vsync === 1'b1, "R7 idle levels follow polarity", int'(hsync), 0);
    chk(de === 1'b0, "R7 de in reset", int'(de), 0);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule